// File: doc/BRIEF.md
# DMA Physical Address Composer

This block builds the 24-bit physical memory address for one DMA cycle. Each channel owns an 8-bit page register that software loads as a single byte, apart from the channel's address and count. When the engine presents a channel number, that channel's 16-bit current address and the channel's transfer width, the block joins the page and the address into a physical address, one clock later. It also produces the byte-lane enables for the cycle and a flag that marks a roll-over of the current address from the top of its window back to zero.

Byte-wide channels place the page directly above the 16 address bits, so each page is a 64K-byte window. Word-wide channels count 16-bit words: the address moves up one bit position, physical bit 0 is held at zero, and page bit 0 is discarded, so each page is a 128K-byte window. In both modes the page never takes a carry. An address that rolls past the top of its window comes back to the base of the same page. Incrementing the address and running the bus cycle belong to the surrounding engine.

Top module: `dma_addr_composer`

## Requirements
- R1: While reset is asserted and after its release, physAddr is 0, byteEn is 2'b00 and wrapFlag is 0. All page registers reset to 0.
- R2: One clock after a cycle with addrValid=1 and wordMode=0, physAddr equals {page of curChan, curAddr}. Page bits 7:0 go to physical bits 23:16.
- R3: One clock after a cycle with addrValid=1 and wordMode=1, physAddr equals {page[7:1] of curChan, curAddr, 1'b0}. Page bit 0 has no effect on the result.
- R4: A cycle with pageWrEn=1 loads pageWrData into the page register picked by pageWrSel and leaves the other channels unchanged. A composition in that same cycle uses the value the register held before the write.
- R5: byteEn is 2'b11 one clock after a word-mode cycle. After a byte-mode cycle it is 2'b01 when physical bit 0 is 0 and 2'b10 when it is 1. It is 2'b00 one clock after any cycle with addrValid=0.
- R6: physAddr keeps its value one clock after any cycle with addrValid=0.
- R7: When a channel presents curAddr=0x0000 and its previous presentation was 0xFFFF, wrapFlag is 1 for exactly the clock in which that result is shown. The physical address then equals the base of the unchanged page (low 16 bits zero in byte mode, bits 16:0 zero in word mode).
- R8: Roll-over tracking is kept per channel. Presentations on other channels do not disturb it. A page write to a channel clears it, including a write in the same cycle as that channel's 0xFFFF presentation.
- R9: The top of a window is reached without carry. Byte channel page 0xFF with address 0xFFFF gives 0xFFFFFF. Word channel page 0xFF with address 0xFFFF gives 0xFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pageWrEn | input | 1 | Page register write strobe |
| pageWrSel | input | 2 | Channel whose page register is written |
| pageWrData | input | 8 | Page value to load |
| addrValid | input | 1 | A DMA cycle is presented this clock |
| curChan | input | 2 | Channel of the presented cycle |
| curAddr | input | 16 | Channel's current address register (bytes or words) |
| wordMode | input | 1 | 1 = word-wide channel, 0 = byte-wide channel |
| physAddr | output | 24 | Composed physical address |
| byteEn | output | 2 | Byte lanes for the cycle; bit 0 low lane, bit 1 high lane |
| wrapFlag | output | 1 | Current address rolled over inside its window |

## Verification
A page write can land in the same clock as a composition on the same channel. That write also clears the channel's roll-over tracking, so it can meet a 0xFFFF presentation or a 0x0000 wrap in one cycle. Directed sequences drive both strobes together on one channel. The bench then expects the old page in the composed address and no wrap on the following 0x0000. A long stretch of random writes and presentations, weighted toward 0xFFFF and 0x0000, makes these collisions occur repeatedly. A behavioural model that applies the write after the composition judges every clock.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  // Strobes handed from the control section to the datapath each cycle
  typedef struct packed {
    logic pageLoad;  // write pageWrData into the selected page register
    logic compose;   // capture a physical address this cycle
    logic wordSel;   // presented channel is word wide
    logic wrap;      // current address rolled from the top back to zero
  } ctlStrobes_t;

  localparam logic [1:0] LANE_NONE = 2'b00;
  localparam logic [1:0] LANE_LOW  = 2'b01;
  localparam logic [1:0] LANE_HIGH = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;

endpackage

// File: rtl/dma_addr_ctl.sv
module dma_addr_ctl
  import dma_addr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWrEn,
  input  logic [CH_W-1:0]   pageWrSel,
  input  logic              addrValid,
  input  logic [CH_W-1:0]   curChan,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              wordMode,
  output ctlStrobes_t       strobes
);

  // One bit per channel: last presentation on this channel was all ones
  logic atTop [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_track
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        atTop[ch] <= 1'b0;
      end else if (pageWrEn && (pageWrSel == CH_W'(ch))) begin
        atTop[ch] <= 1'b0;
      end else if (addrValid && (curChan == CH_W'(ch))) begin
        atTop[ch] <= &curAddr;
      end
    end
  end

  always_comb begin
    strobes.pageLoad = pageWrEn;
    strobes.compose  = addrValid;
    strobes.wordSel  = wordMode;
    strobes.wrap     = addrValid && atTop[curChan] && (curAddr == '0);
  end

endmodule

// File: rtl/dma_addr_dp.sv
module dma_addr_dp
  import dma_addr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CH_W   = 2,
  parameter int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CH_W-1:0]   pageWrSel,
  input  logic [PAGE_W-1:0] pageWrData,
  input  logic [CH_W-1:0]   curChan,
  input  logic [ADDR_W-1:0] curAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        byteEn,
  output logic              wrapFlag
);

  logic [PAGE_W-1:0] pageReg [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_page
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageReg[ch] <= '0;
      end else if (strobes.pageLoad && (pageWrSel == CH_W'(ch))) begin
        pageReg[ch] <= pageWrData;
      end
    end
  end

  logic [PAGE_W-1:0] selPage;
  logic [PHYS_W-1:0] byteForm;
  logic [PHYS_W-1:0] wordForm;
  logic [1:0]        laneSel;

  always_comb begin
    selPage  = pageReg[curChan];
    byteForm = {selPage, curAddr};
    wordForm = {selPage[PAGE_W-1:1], curAddr, 1'b0};
    if (strobes.wordSel) begin
      laneSel = LANE_BOTH;
    end else begin
      laneSel = curAddr[0] ? LANE_HIGH : LANE_LOW;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      byteEn   <= LANE_NONE;
      wrapFlag <= 1'b0;
    end else begin
      wrapFlag <= strobes.wrap;
      if (strobes.compose) begin
        physAddr <= strobes.wordSel ? wordForm : byteForm;
        byteEn   <= laneSel;
      end else begin
        byteEn   <= LANE_NONE;
      end
    end
  end

endmodule

// File: rtl/dma_addr_composer.sv
module dma_addr_composer
  import dma_addr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pageWrEn,
  input  logic [CH_W-1:0]          pageWrSel,
  input  logic [PAGE_W-1:0]        pageWrData,
  input  logic                     addrValid,
  input  logic [CH_W-1:0]          curChan,
  input  logic [ADDR_W-1:0]        curAddr,
  input  logic                     wordMode,
  output logic [PAGE_W+ADDR_W-1:0] physAddr,
  output logic [1:0]               byteEn,
  output logic                     wrapFlag
);

  localparam int PHYS_W = PAGE_W + ADDR_W;

  ctlStrobes_t strobes;

  dma_addr_ctl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .pageWrEn (pageWrEn),
    .pageWrSel(pageWrSel),
    .addrValid(addrValid),
    .curChan  (curChan),
    .curAddr  (curAddr),
    .wordMode (wordMode),
    .strobes  (strobes)
  );

  dma_addr_dp #(
    .NUM_CH(NUM_CH), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W),
    .CH_W(CH_W), .PHYS_W(PHYS_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pageWrSel (pageWrSel),
    .pageWrData(pageWrData),
    .curChan   (curChan),
    .curAddr   (curAddr),
    .physAddr  (physAddr),
    .byteEn    (byteEn),
    .wrapFlag  (wrapFlag)
  );

endmodule

// File: rtl/dma_addr_composer_chk.sv
module dma_addr_composer_chk #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     addrValid,
  input logic                     wordMode,
  input logic [ADDR_W-1:0]        curAddr,
  input logic [PAGE_W+ADDR_W-1:0] physAddr,
  input logic [1:0]               byteEn,
  input logic                     wrapFlag
);

  assert_byte_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !wordMode |=> physAddr[ADDR_W-1:0] == $past(curAddr));

  assert_word_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && wordMode |=> physAddr[ADDR_W:1] == $past(curAddr) && !physAddr[0]);

  assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !wordMode |=> $countones(byteEn) == 1);

  assert_word_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && wordMode |=> byteEn == 2'b11);

  assert_idle_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> byteEn == 2'b00);

  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> $stable(physAddr));

  assert_wrap_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrapFlag |-> physAddr[ADDR_W-1:0] == '0 && byteEn != 2'b00);

  assert_wrap_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrapFlag |-> $past(addrValid) && $past(curAddr) == '0);

endmodule

bind dma_addr_composer dma_addr_composer_chk #(
  .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrValid(addrValid),
  .wordMode (wordMode),
  .curAddr  (curAddr),
  .physAddr (physAddr),
  .byteEn   (byteEn),
  .wrapFlag (wrapFlag)
);

// File: tb/test_dma_addr_composer.sv
module test_dma_addr_composer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageWrEn = 1'b0;
  logic [1:0]  pageWrSel = '0;
  logic [7:0]  pageWrData = '0;
  logic        addrValid = 1'b0;
  logic [1:0]  curChan = '0;
  logic [15:0] curAddr = '0;
  logic        wordMode = 1'b0;
  logic [23:0] physAddr;
  logic [1:0]  byteEn;
  logic        wrapFlag;

  int testsRun = 0;
  int testsFailed = 0;

  dma_addr_composer i_dma_addr_composer (
    .clk(clk), .rstN(rstN), .pageWrEn(pageWrEn), .pageWrSel(pageWrSel),
    .pageWrData(pageWrData), .addrValid(addrValid), .curChan(curChan),
    .curAddr(curAddr), .wordMode(wordMode), .physAddr(physAddr),
    .byteEn(byteEn), .wrapFlag(wrapFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int   pages [NCH];
  bit   lastTop [NCH];
  int   expPhys = 0;
  int   expBe = 0;
  bit   expWrap = 0;
  bit   expWordCyc = 0;
  bit   expInReset = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin pages[i] = 0; lastTop[i] = 0; end
      expPhys = 0; expBe = 0; expWrap = 0; expInReset = 1;
    end else begin
      expInReset = 0;
      if (addrValid) begin
        if (wordMode) begin
          expPhys = (pages[curChan] & 254) * 65536 + int'(curAddr) * 2;
          expBe = 3;
        end else begin
          expPhys = pages[curChan] * 65536 + int'(curAddr);
          expBe = curAddr[0] ? 2 : 1;
        end
        expWordCyc = wordMode;
        expWrap = lastTop[curChan] && (curAddr == 16'h0000);
        lastTop[curChan] = (curAddr == 16'hFFFF);
      end else begin
        expBe = 0;
        expWrap = 0;
      end
      if (pageWrEn) begin
        pages[pageWrSel] = int'(pageWrData);
        lastTop[pageWrSel] = 0;
      end
    end
  end

  task automatic checkVal(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compared on every clock, away from the active edge
  always @(negedge clk) begin
    string addrTag;
    if (expInReset) addrTag = "R1";
    else if (expBe == 0) addrTag = "R6";
    else if (expWordCyc) addrTag = "R3";
    else addrTag = "R2";
    checkVal(addrTag, "physAddr", int'(physAddr), expPhys);
    checkVal(expInReset ? "R1" : "R5", "byteEn", int'(byteEn), expBe);
    checkVal(expInReset ? "R1" : "R7", "wrapFlag", int'(wrapFlag), int'(expWrap));
  end

  task automatic writePage(int ch, int val);
    @(negedge clk);
    pageWrEn = 1; pageWrSel = 2'(ch); pageWrData = 8'(val);
    @(negedge clk);
    pageWrEn = 0;
  endtask

  task automatic present(int ch, int addr, bit word);
    @(negedge clk);
    addrValid = 1; curChan = 2'(ch); curAddr = 16'(addr); wordMode = word;
    @(negedge clk);
    addrValid = 0;
  endtask

  task automatic presentAndWrite(int ch, int addr, bit word, int val);
    @(negedge clk);
    addrValid = 1; curChan = 2'(ch); curAddr = 16'(addr); wordMode = word;
    pageWrEn = 1; pageWrSel = 2'(ch); pageWrData = 8'(val);
    @(negedge clk);
    addrValid = 0; pageWrEn = 0;
  endtask

  task automatic stream(int ch, int startAddr, int n, bit word);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      addrValid = 1; curChan = 2'(ch); curAddr = 16'(startAddr + k); wordMode = word;
    end
    @(negedge clk);
    addrValid = 0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired before the stimulus completed");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R1", "physAddr in reset", int'(physAddr), 0);
    rstN = 1;
    @(negedge clk);
    // Page registers cleared by reset
    present(2, 16'h00AB, 0);
    checkVal("R1", "page after reset", int'(physAddr), 24'h0000AB);

    writePage(0, 8'h12);
    writePage(1, 8'h35);
    writePage(2, 8'hA7);
    writePage(3, 8'hFF);

    present(0, 16'h1234, 0);
    checkVal("R2", "byte compose", int'(physAddr), 24'h121234);
    checkVal("R5", "byte low lane", int'(byteEn), 1);
    present(0, 16'h0001, 0);
    checkVal("R5", "byte high lane", int'(byteEn), 2);

    present(1, 16'h1234, 1);
    checkVal("R3", "word compose, page bit 0 dropped", int'(physAddr), 24'h342468);
    checkVal("R5", "word lanes", int'(byteEn), 3);

    present(3, 16'hFFFF, 0);
    checkVal("R9", "byte window top", int'(physAddr), 24'hFFFFFF);
    present(3, 16'hFFFF, 1);
    checkVal("R9", "word window top", int'(physAddr), 24'hFFFFFE);
    repeat (3) @(negedge clk);
    checkVal("R6", "hold while idle", int'(physAddr), 24'hFFFFFE);

    // Same-cycle write and composition use the old page
    presentAndWrite(2, 16'h0010, 0, 8'h40);
    checkVal("R4", "old page in write cycle", int'(physAddr), 24'hA70010);
    present(2, 16'h0010, 0);
    checkVal("R4", "new page after write", int'(physAddr), 24'h400010);
    present(0, 16'h0000, 0);
    checkVal("R4", "other channel untouched", int'(physAddr), 24'h120000);

    // Roll-over inside the window
    stream(0, 16'hFFFE, 4, 0);
    stream(1, 16'hFFFD, 5, 1);
    present(1, 16'hFFFF, 1);
    present(1, 16'h0000, 1);
    checkVal("R7", "word wrap flag", int'(wrapFlag), 1);
    checkVal("R7", "word wrap to page base", int'(physAddr), 24'h340000);

    // Per-channel tracking
    present(2, 16'hFFFF, 0);
    present(3, 16'h1000, 1);
    present(2, 16'h0000, 0);
    checkVal("R8", "interleaved wrap kept", int'(wrapFlag), 1);
    present(0, 16'hFFFF, 0);
    writePage(0, 8'h66);
    present(0, 16'h0000, 0);
    checkVal("R8", "write clears tracking", int'(wrapFlag), 0);
    presentAndWrite(3, 16'hFFFF, 0, 8'h09);
    present(3, 16'h0000, 0);
    checkVal("R8", "same-cycle write clears tracking", int'(wrapFlag), 0);
    checkVal("R8", "new page base", int'(physAddr), 24'h090000);

    // Random traffic biased toward window edges
    for (int it = 0; it < 3000; it++) begin
      int sel;
      @(negedge clk);
      pageWrEn = ($urandom % 4) == 0;
      pageWrSel = 2'($urandom);
      pageWrData = 8'($urandom);
      addrValid = ($urandom % 3) != 0;
      curChan = 2'($urandom);
      wordMode = 1'($urandom);
      sel = $urandom % 4;
      curAddr = (sel == 0) ? 16'hFFFF : (sel == 1) ? 16'h0000 : 16'($urandom);
    end
    @(negedge clk);
    pageWrEn = 0; addrValid = 0;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule